// File: doc/BRIEF.md
# Fixed-Point Compare to Condition Field

This block compares two integers and writes the result into a condition register. The first operand always comes from a register. The second comes from a register or from a 16-bit immediate. The comparison can be signed or unsigned, and it can use the full 64-bit width or only the low 32 bits of the register operands.

The result is a 4-bit nibble. Its top three bits are a one-hot code for less-than, greater-than or equal. Its lowest bit is a copy of the summary-overflow input. The nibble is written into one of eight 4-bit fields of a 32-bit condition register. A 3-bit index selects the field.

The write takes place on the clock edge at which the valid strobe is high. The other seven fields keep their values. The comparison itself is combinational.

Top module: `cmp_cond_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the whole condition register to zero.
- R2: With `isWide`=1 and `isSigned`=1, the two 64-bit operands are compared as two's-complement values.
- R3: With `isWide`=1 and `isSigned`=0, the two 64-bit operands are compared as unsigned values.
- R4: With `isWide`=0 and `isSigned`=1, only bits 31:0 of each register operand are used, sign-extended from bit 31. Bits 63:32 have no effect on the result.
- R5: With `isWide`=0 and `isSigned`=0, only bits 31:0 of each register operand are used, zero-extended. Bits 63:32 have no effect on the result.
- R6: With `useImm`=1 and `isSigned`=1, the second operand is the 16-bit immediate sign-extended to 64 bits, and `opB` is ignored.
- R7: With `useImm`=1 and `isSigned`=0, the second operand is the immediate zero-extended to 64 bits. The immediate is never truncated by `isWide`.
- R8: The written nibble is {LT, GT, EQ, SO}, from bit 3 down to bit 0:
  - less-than gives 4'b100s;
  - greater-than gives 4'b010s;
  - equal gives 4'b001s;
  - s is the value of `sumOvf` in the write cycle.
- R9: Field index k occupies `condReg[31-4k : 28-4k]`, so field 0 is the most significant nibble. The LT bit sits at the highest position of the field.
- R10: A write changes only the selected field. The other seven fields hold their values.
- R11: The register changes only on an edge where `valid` is high. The new value is visible at the output from that edge on, and it holds while `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Write strobe for the compare result |
| opA | input | 64 | First register operand |
| opB | input | 64 | Second register operand |
| imm | input | 16 | Immediate operand |
| useImm | input | 1 | 1 selects the immediate as the second operand |
| isSigned | input | 1 | 1 selects a signed compare and sign extension |
| isWide | input | 1 | 1 compares 64 bits, 0 compares the low 32 bits |
| fieldIdx | input | 3 | Target field index |
| sumOvf | input | 1 | Summary-overflow bit copied into the nibble |
| condReg | output | 32 | Condition register |

## Verification
A compare is presented on `valid` at one falling edge. Its nibble is due in `condReg` exactly one rising edge later, so the bench samples at the following falling edge and compares the whole register against a behavioural model. That model extends operands to 65 bits and uses native signed compares. Idle cycles are checked the same way, which confirms that nothing moves without the strobe. The stimulus pairs the most negative and most positive values in both signedness modes, so that the signed and unsigned orderings disagree. It also places different values in the upper bits in word mode, to show they have no effect.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int XLEN   = 64;
  localparam int IMMW   = 16;
  localparam int NFIELD = 8;
  localparam int NIB    = 4;
  localparam int CRW    = NFIELD * NIB;
  localparam int IDXW   = $clog2(NFIELD);

  typedef struct packed {
    logic              clear;
    logic [NFIELD-1:0] wrMask;
  } cmpuStrobe_t;
endpackage

// File: rtl/cmpu_ctrl.sv
module cmpu_ctrl
  import cmpu_pkg::*;
(
  input  logic            rst,
  input  logic            valid,
  input  logic [IDXW-1:0] fieldIdx,
  output cmpuStrobe_t     strobe
);
  // One-hot write mask: one enable per field, raised only with the strobe
  always_comb begin
    strobe.clear  = rst;
    strobe.wrMask = '0;
    for (int k = 0; k < NFIELD; k++) begin
      strobe.wrMask[k] = valid && (fieldIdx == IDXW'(k));
    end
  end
endmodule

// File: rtl/cmpu_datapath.sv
module cmpu_datapath
  import cmpu_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int IW   = IMMW,
  parameter int NF   = NFIELD,
  parameter int NW   = NIB
) (
  input  logic            clk,
  input  cmpuStrobe_t     strobe,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic [IW-1:0]   imm,
  input  logic            useImm,
  input  logic            isSigned,
  input  logic            isWide,
  input  logic            sumOvf,
  output logic [NF*NW-1:0] condReg
);
  localparam int HALF = W / 2;

  logic [W-1:0] extA, regB, immExt, extB, keyA, keyB;
  logic         ltBit, eqBit, gtBit;
  logic [NW-1:0] resNib;

  // Operand shaping: low half extended in word mode
  always_comb begin
    extA   = isWide ? opA : {{HALF{isSigned & opA[HALF-1]}}, opA[HALF-1:0]};
    regB   = isWide ? opB : {{HALF{isSigned & opB[HALF-1]}}, opB[HALF-1:0]};
    immExt = {{(W-IW){isSigned & imm[IW-1]}}, imm};
    extB   = useImm ? immExt : regB;
  end

  // Signed order becomes unsigned order once the sign bit is flipped
  always_comb begin
    keyA  = extA ^ {isSigned, {(W-1){1'b0}}};
    keyB  = extB ^ {isSigned, {(W-1){1'b0}}};
    ltBit = keyA < keyB;
    eqBit = extA == extB;
    gtBit = !ltBit && !eqBit;
    resNib = {ltBit, gtBit, eqBit, sumOvf};
  end

  // Field k is stored at the k-th nibble counting from the top
  generate
    for (genvar k = 0; k < NF; k++) begin : gField
      always_ff @(posedge clk) begin
        if (strobe.clear) begin
          condReg[(NF-1-k)*NW +: NW] <= '0;
        end else if (strobe.wrMask[k]) begin
          condReg[(NF-1-k)*NW +: NW] <= resNib;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cmp_cond_unit.sv
module cmp_cond_unit
  import cmpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic [63:0]     opA,
  input  logic [63:0]     opB,
  input  logic [15:0]     imm,
  input  logic            useImm,
  input  logic            isSigned,
  input  logic            isWide,
  input  logic [2:0]      fieldIdx,
  input  logic            sumOvf,
  output logic [31:0]     condReg
);
  cmpuStrobe_t strobe;

  cmpu_ctrl uCtrl (
    .rst      (rst),
    .valid    (valid),
    .fieldIdx (fieldIdx),
    .strobe   (strobe)
  );

  cmpu_datapath uDp (
    .clk      (clk),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .imm      (imm),
    .useImm   (useImm),
    .isSigned (isSigned),
    .isWide   (isWide),
    .sumOvf   (sumOvf),
    .condReg  (condReg)
  );
endmodule

// File: rtl/cmp_cond_unit_chk.sv
module cmp_cond_unit_chk
  import cmpu_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            valid,
  input logic [63:0]     opA,
  input logic [63:0]     opB,
  input logic            useImm,
  input logic [2:0]      fieldIdx,
  input logic            sumOvf,
  input logic [31:0]     condReg
);
  logic [2:0]     lastIdx;
  logic [NIB-1:0] curField;
  logic [31:0]    otherMask;

  always_ff @(posedge clk) begin
    lastIdx <= fieldIdx;
  end

  always_comb begin
    curField  = '0;
    otherMask = '1;
    for (int k = 0; k < NFIELD; k++) begin
      if (lastIdx == 3'(k)) begin
        curField = condReg[(NFIELD-1-k)*NIB +: NIB];
        otherMask[(NFIELD-1-k)*NIB +: NIB] = '0;
      end
    end
  end

  // R11: no strobe, no change
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(condReg));

  // R8: exactly one of LT/GT/EQ set in the written field
  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    valid |=> $countones(curField[3:1]) == 1);

  // R8: low bit of the written field copies the overflow input
  assert_so_copy_R8: assert property (@(posedge clk) disable iff (rst)
    valid |=> curField[0] == $past(sumOvf));

  // R10: the unselected fields keep their values
  assert_others_kept_R10: assert property (@(posedge clk) disable iff (rst)
    valid |=> (condReg & otherMask) == ($past(condReg) & otherMask));

  // R2: identical register operands compare equal
  assert_equal_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && !useImm && opA == opB) |=> curField[3:1] == 3'b001);
endmodule

bind cmp_cond_unit cmp_cond_unit_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .valid    (valid),
  .opA      (opA),
  .opB      (opB),
  .useImm   (useImm),
  .fieldIdx (fieldIdx),
  .sumOvf   (sumOvf),
  .condReg  (condReg)
);

// File: tb/tb_cmp_cond_unit.sv
module tb_cmp_cond_unit;
  logic        clk = 1'b0;
  logic        rst, valid, useImm, isSigned, isWide, sumOvf;
  logic [63:0] opA, opB;
  logic [15:0] imm;
  logic [2:0]  fieldIdx;
  logic [31:0] condReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] refCr;

  always #4 clk = ~clk;  // 125 MHz

  cmp_cond_unit dut (
    .clk(clk), .rst(rst), .valid(valid), .opA(opA), .opB(opB), .imm(imm),
    .useImm(useImm), .isSigned(isSigned), .isWide(isWide),
    .fieldIdx(fieldIdx), .sumOvf(sumOvf), .condReg(condReg)
  );

  localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  function automatic logic [3:0] refNib(input logic [63:0] a, input logic [63:0] b,
      input logic [15:0] im, input bit ui, input bit sg, input bit wd, input bit so);
    logic signed [64:0] x, y;
    if (wd) begin
      x = {sg & a[63], a};
      y = {sg & b[63], b};
    end else begin
      x = {{33{sg & a[31]}}, a[31:0]};
      y = {{33{sg & b[31]}}, b[31:0]};
    end
    if (ui) y = {{49{sg & im[15]}}, im};
    if (x < y)      return {3'b100, so};
    else if (x > y) return {3'b010, so};
    else            return {3'b001, so};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (condReg !== refCr) begin
      fails++;
      $display("FAIL %s: condReg=%h expected=%h", tag, condReg, refCr);
    end
  endtask

  task automatic doCmp(input string tag, input logic [63:0] a, input logic [63:0] b,
      input logic [15:0] im, input bit ui, input bit sg, input bit wd,
      input int f, input bit so);
    @(negedge clk);
    opA = a; opB = b; imm = im; useImm = ui; isSigned = sg; isWide = wd;
    fieldIdx = 3'(f); sumOvf = so; valid = 1'b1;
    refCr[31-4*f -: 4] = refNib(a, b, im, ui, sg, wd, so);
    @(negedge clk);
    valid = 1'b0;
    check(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    opA = ~opA; opB = 64'h5; fieldIdx = fieldIdx + 3'd1; sumOvf = ~sumOvf;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; valid = 1'b0; opA = '0; opB = '0; imm = '0;
    useImm = 0; isSigned = 0; isWide = 0; fieldIdx = '0; sumOvf = 0;
    refCr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset");

    // R9: field placement sweep, each field gets a distinct result
    for (int f = 0; f < 8; f++)
      doCmp("R9 field", 64'(f), 64'd3, 16'h0, 0, 1, 1, f, f[0]);

    // R2: signed wide extremes
    doCmp("R2 min<max", MINS, MAXS, 16'h0, 0, 1, 1, 0, 0);
    doCmp("R2 max>min", MAXS, MINS, 16'h0, 0, 1, 1, 1, 1);
    doCmp("R2 min==min", MINS, MINS, 16'h0, 0, 1, 1, 2, 0);
    doCmp("R2 -1<0", ALL1, 64'h0, 16'h0, 0, 1, 1, 3, 0);
    // R3: unsigned wide extremes, ordering reversed from signed
    doCmp("R3 min>max", MINS, MAXS, 16'h0, 0, 0, 1, 4, 0);
    doCmp("R3 max<min", MAXS, MINS, 16'h0, 0, 0, 1, 5, 1);
    doCmp("R3 all1>0", ALL1, 64'h0, 16'h0, 0, 0, 1, 6, 0);
    doCmp("R3 all1==all1", ALL1, ALL1, 16'h0, 0, 0, 1, 7, 1);
    // R4: signed word, upper bits differ but ignored
    doCmp("R4 word min<max", 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 16'h0, 0, 1, 0, 0, 0);
    doCmp("R4 word eq", 64'h1234_5678_0000_0042, 64'h9ABC_DEF0_0000_0042, 16'h0, 0, 1, 0, 1, 0);
    doCmp("R4 word -1<1", 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 16'h0, 0, 1, 0, 2, 1);
    // R5: unsigned word
    doCmp("R5 word min>max", 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 16'h0, 0, 0, 0, 3, 0);
    doCmp("R5 word eq", 64'hFFFF_0000_0000_0007, 64'h0000_FFFF_0000_0007, 16'h0, 0, 0, 0, 4, 1);
    // R6: signed immediate
    doCmp("R6 imm -32768 eq", 64'hFFFF_FFFF_FFFF_8000, ALL1, 16'h8000, 1, 1, 1, 5, 0);
    doCmp("R6 imm 0 > -1", 64'h0, 64'h0, 16'hFFFF, 1, 1, 1, 6, 0);
    doCmp("R6 imm word min<max", 64'h0000_0000_8000_0000, 64'h0, 16'h7FFF, 1, 1, 0, 7, 1);
    // R7: unsigned immediate
    doCmp("R7 imm 0 < 65535", 64'h0, ALL1, 16'hFFFF, 1, 0, 1, 0, 0);
    doCmp("R7 imm eq 32768", 64'h8000, 64'h0, 16'h8000, 1, 0, 0, 1, 0);
    doCmp("R7 imm max>imm", MAXS, 64'h0, 16'hFFFF, 1, 0, 1, 2, 1);
    // R8: overflow bit follows sumOvf across outcomes
    doCmp("R8 so lt", 64'd1, 64'd2, 16'h0, 0, 0, 1, 3, 1);
    doCmp("R8 so gt", 64'd2, 64'd1, 16'h0, 0, 0, 1, 3, 0);
    // R10/R11: idle cycles change nothing
    idle("R11 idle");
    idle("R10 idle");
    // R1: reset mid-run
    @(negedge clk); rst = 1'b1; valid = 1'b1;
    @(negedge clk); rst = 1'b0; valid = 1'b0; refCr = '0;
    check("R1 reset after use");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule